// File: doc/BRIEF.md
# Counted-Loop Branch and Rotation Controller

This block keeps the state behind counted-loop branches in software-pipelined loops. It holds a 64-bit iteration counter, a 6-bit drain counter, one rename base for the rotating predicate region and one for the rotating floating-point region, and a stage-valid bit. Each loop-branch request sorts the present counter values into one of four phases: kernel, drain, last drain, or done. It then updates the state for that phase and reports whether the branch is taken. Because of this, a software pipeline fills and drains with no extra instructions.

Two requests differ only in how the phase maps to taken. The "continue" kind stays in the loop while work remains. The "leave" kind is taken once the loop has run out. Two combinational mappers turn logical rotating register numbers into physical ones using the current rename bases. A rotation makes the value seen at a logical number L appear at L+1, and the top of each region wraps to its bottom.

Top module: `loopctl_top`

## Requirements
- R1: After reset the iteration counter, drain counter, both rename bases and the stage-valid bit are all zero.
- R2: A write strobe loads its counter on the next clock edge. If a write and a branch request arrive in the same cycle, the written value wins for that counter, while the rename bases and the stage-valid bit still follow the branch.
- R3: Kernel phase (iteration counter nonzero): the counter decreases by one, the drain counter is kept, stage-valid becomes 1 and both rename bases decrease by one.
- R4: Drain phase (iteration counter zero, drain counter above 1): the iteration counter is kept, the drain counter decreases by one, stage-valid becomes 0 and both rename bases decrease by one.
- R5: Last-drain phase (iteration counter zero, drain counter equal to 1): the drain counter becomes 0, stage-valid becomes 0 and both rename bases decrease by one.
- R6: Done phase (both counters zero): a branch request changes no state, including the rename bases.
- R7: With `br_kind` = 0 (continue), `br_taken` is 1 in the kernel and drain phases and 0 in the last-drain and done phases. `br_taken` is 0 in any cycle without `br_valid`. It is valid in the same cycle as the request.
- R8: With `br_kind` = 1 (leave), `br_taken` is the inverse of the R7 result in every phase.
- R9: The predicate rename base counts modulo 48 and the floating-point rename base counts modulo 96, so decreasing from 0 gives 47 and 95 respectively.
- R10: Predicate numbers 16 to 63 map to 16 + ((n − 16 + predicate base) mod 48). Numbers 0 to 15 map to themselves.
- R11: Floating-point numbers 32 to 127 map to 32 + ((n − 32 + float base) mod 96). Numbers 0 to 31 map to themselves.
- R12: In a cycle with no branch request and no write, all state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_wr_en | input | 1 | Load the iteration counter |
| lc_wr_data | input | 64 | Value for the iteration counter |
| ec_wr_en | input | 1 | Load the drain counter |
| ec_wr_data | input | 6 | Value for the drain counter |
| br_valid | input | 1 | Loop-branch request this cycle |
| br_kind | input | 1 | 0 = continue kind, 1 = leave kind |
| br_taken | output | 1 | Branch result for the current request |
| loop_cnt | output | 64 | Iteration counter |
| epi_cnt | output | 6 | Drain counter |
| rrb_pred | output | 6 | Predicate rename base (0 to 47) |
| rrb_fp | output | 7 | Floating-point rename base (0 to 95) |
| stage_pred | output | 1 | Stage-valid predicate |
| pr_log_idx | input | 6 | Logical predicate number to map |
| pr_phys_idx | output | 6 | Physical predicate number |
| fr_log_idx | input | 7 | Logical floating-point number to map |
| fr_phys_idx | output | 7 | Physical floating-point number |

## Verification
The counter-update properties assume that no write strobe is active in the cycle they inspect. Each of them is therefore qualified on the write enables, and only the write-priority scenario drives a write and a branch together. The mapping properties assume that logical indices stay inside the port width, which the stimulus does by sweeping only 0 to 63 and 0 to 127. The bench reaches every phase from counter values that it writes itself, including a full-width iteration count and base wrap from zero.

// File: rtl/loopctl_pkg.sv
package loopctl_pkg;
    typedef enum logic [1:0] {
        LB_KERNEL = 2'd0,
        LB_DRAIN  = 2'd1,
        LB_LAST   = 2'd2,
        LB_DONE   = 2'd3
    } lb_phase_e;
endpackage

// File: rtl/loopctl_decide.sv
module loopctl_decide
    import loopctl_pkg::*;
#(
    parameter int LC_W = 64,
    parameter int EC_W = 6
) (
    input  logic [LC_W-1:0] lc,
    input  logic [EC_W-1:0] ec,
    input  logic            leave_kind,
    output lb_phase_e       phase,
    output logic            taken
);
    localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

    // phase from counters; continue kind stays in loop for kernel and drain
    always_comb begin
        if (lc != '0)          phase = LB_KERNEL;
        else if (ec > EC_ONE)  phase = LB_DRAIN;
        else if (ec == EC_ONE) phase = LB_LAST;
        else                   phase = LB_DONE;
        taken = ((phase == LB_KERNEL) || (phase == LB_DRAIN)) ^ leave_kind;
    end
endmodule

// File: rtl/loopctl_rotmap.sv
module loopctl_rotmap #(
    parameter int NUM = 64,
    parameter int LO  = 16,
    localparam int IDX_W = $clog2(NUM),
    localparam int SZ    = NUM - LO,
    localparam int B_W   = $clog2(SZ)
) (
    input  logic [B_W-1:0]   base,
    input  logic [IDX_W-1:0] log_idx,
    output logic [IDX_W-1:0] phys_idx
);
    localparam logic [IDX_W:0] LO_X = (IDX_W+1)'(LO);
    localparam logic [IDX_W:0] SZ_X = (IDX_W+1)'(SZ);

    logic [IDX_W:0] off_x;
    logic [IDX_W:0] sum_x;
    logic [IDX_W:0] fin_x;

    always_comb begin
        off_x = {1'b0, log_idx} - LO_X;
        sum_x = off_x + {{(IDX_W+1-B_W){1'b0}}, base};
        if (sum_x >= SZ_X) sum_x = sum_x - SZ_X;
        fin_x = sum_x + LO_X;
        if ({1'b0, log_idx} < LO_X) phys_idx = log_idx;
        else                        phys_idx = fin_x[IDX_W-1:0];
    end
endmodule

// File: rtl/loopctl_top.sv
module loopctl_top
    import loopctl_pkg::*;
#(
    parameter int LC_W   = 64,
    parameter int EC_W   = 6,
    parameter int PR_NUM = 64,
    parameter int PR_LO  = 16,
    parameter int FR_NUM = 128,
    parameter int FR_LO  = 32,
    localparam int PR_IW = $clog2(PR_NUM),
    localparam int FR_IW = $clog2(FR_NUM),
    localparam int PR_SZ = PR_NUM - PR_LO,
    localparam int FR_SZ = FR_NUM - FR_LO,
    localparam int PRB_W = $clog2(PR_SZ),
    localparam int FRB_W = $clog2(FR_SZ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lc_wr_en,
    input  logic [LC_W-1:0]  lc_wr_data,
    input  logic             ec_wr_en,
    input  logic [EC_W-1:0]  ec_wr_data,
    input  logic             br_valid,
    input  logic             br_kind,
    output logic             br_taken,
    output logic [LC_W-1:0]  loop_cnt,
    output logic [EC_W-1:0]  epi_cnt,
    output logic [PRB_W-1:0] rrb_pred,
    output logic [FRB_W-1:0] rrb_fp,
    output logic             stage_pred,
    input  logic [PR_IW-1:0] pr_log_idx,
    output logic [PR_IW-1:0] pr_phys_idx,
    input  logic [FR_IW-1:0] fr_log_idx,
    output logic [FR_IW-1:0] fr_phys_idx
);
    localparam logic [PRB_W-1:0] PR_TOP = PRB_W'(PR_SZ - 1);
    localparam logic [FRB_W-1:0] FR_TOP = FRB_W'(FR_SZ - 1);

    typedef struct packed {
        logic [LC_W-1:0]  lc;
        logic [EC_W-1:0]  ec;
        logic [PRB_W-1:0] rrb_pr;
        logic [FRB_W-1:0] rrb_fr;
        logic             stage;
    } lctl_state_t;

    lctl_state_t st_d, st_q;
    lb_phase_e   phase;
    logic        taken_raw;
    logic [PRB_W-1:0] rrb_pr_dn;
    logic [FRB_W-1:0] rrb_fr_dn;

    loopctl_decide #(.LC_W(LC_W), .EC_W(EC_W)) i_decide (
        .lc         (st_q.lc),
        .ec         (st_q.ec),
        .leave_kind (br_kind),
        .phase      (phase),
        .taken      (taken_raw)
    );

    always_comb begin
        rrb_pr_dn = (st_q.rrb_pr == '0) ? PR_TOP : st_q.rrb_pr - PRB_W'(1);
        rrb_fr_dn = (st_q.rrb_fr == '0) ? FR_TOP : st_q.rrb_fr - FRB_W'(1);
        st_d = st_q;
        if (br_valid) begin
            unique case (phase)
                LB_KERNEL: begin
                    st_d.lc     = st_q.lc - LC_W'(1);
                    st_d.stage  = 1'b1;
                    st_d.rrb_pr = rrb_pr_dn;
                    st_d.rrb_fr = rrb_fr_dn;
                end
                LB_DRAIN, LB_LAST: begin
                    st_d.ec     = st_q.ec - EC_W'(1);
                    st_d.stage  = 1'b0;
                    st_d.rrb_pr = rrb_pr_dn;
                    st_d.rrb_fr = rrb_fr_dn;
                end
                default: ;
            endcase
        end
        if (lc_wr_en) st_d.lc = lc_wr_data;
        if (ec_wr_en) st_d.ec = ec_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign br_taken   = br_valid & taken_raw;
    assign loop_cnt   = st_q.lc;
    assign epi_cnt    = st_q.ec;
    assign rrb_pred   = st_q.rrb_pr;
    assign rrb_fp     = st_q.rrb_fr;
    assign stage_pred = st_q.stage;

    loopctl_rotmap #(.NUM(PR_NUM), .LO(PR_LO)) i_map_pr (
        .base     (st_q.rrb_pr),
        .log_idx  (pr_log_idx),
        .phys_idx (pr_phys_idx)
    );

    loopctl_rotmap #(.NUM(FR_NUM), .LO(FR_LO)) i_map_fr (
        .base     (st_q.rrb_fr),
        .log_idx  (fr_log_idx),
        .phys_idx (fr_phys_idx)
    );

    AST_KERNEL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && loop_cnt != '0 && !lc_wr_en && !ec_wr_en)
        |=> (loop_cnt == $past(loop_cnt) - LC_W'(1)) && $stable(epi_cnt) && stage_pred); // R3
    AST_DRAIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && loop_cnt == '0 && epi_cnt != '0 && !lc_wr_en && !ec_wr_en)
        |=> (epi_cnt == $past(epi_cnt) - EC_W'(1)) && $stable(loop_cnt) && !stage_pred); // R4
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && loop_cnt == '0 && epi_cnt == '0 && !lc_wr_en && !ec_wr_en)
        |=> $stable(loop_cnt) && $stable(epi_cnt) && $stable(rrb_pred) && $stable(rrb_fp) && $stable(stage_pred)); // R6
    AST_NO_REQ_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> !br_taken); // R7
    AST_PR_BASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && (loop_cnt != '0 || epi_cnt != '0) && rrb_pred == '0)
        |=> rrb_pred == PR_TOP); // R9
    AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rrb_pred <= PR_TOP) && (rrb_fp <= FR_TOP)); // R9
    AST_PR_MAP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_log_idx >= PR_IW'(PR_LO)) |-> (pr_phys_idx >= PR_IW'(PR_LO))); // R10
    AST_FR_MAP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_log_idx >= FR_IW'(FR_LO)) |-> (fr_phys_idx >= FR_IW'(FR_LO))); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !lc_wr_en && !ec_wr_en)
        |=> $stable(loop_cnt) && $stable(epi_cnt) && $stable(rrb_pred) && $stable(rrb_fp) && $stable(stage_pred)); // R12
endmodule

// File: tb/test_loopctl_top.sv
module test_loopctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lc_wr_en = 1'b0;
    logic [63:0] lc_wr_data = '0;
    logic        ec_wr_en = 1'b0;
    logic [5:0]  ec_wr_data = '0;
    logic        br_valid = 1'b0;
    logic        br_kind = 1'b0;
    logic        br_taken;
    logic [63:0] loop_cnt;
    logic [5:0]  epi_cnt;
    logic [5:0]  rrb_pred;
    logic [6:0]  rrb_fp;
    logic        stage_pred;
    logic [5:0]  pr_log_idx = '0;
    logic [5:0]  pr_phys_idx;
    logic [6:0]  fr_log_idx = '0;
    logic [6:0]  fr_phys_idx;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [63:0] m_lc;
    logic [5:0]  m_ec;
    int          m_rp, m_rf;
    logic        m_st;

    always #10 clk = ~clk;

    loopctl_top i_loopctl_top (
        .clk, .rst_n, .lc_wr_en, .lc_wr_data, .ec_wr_en, .ec_wr_data,
        .br_valid, .br_kind, .br_taken, .loop_cnt, .epi_cnt, .rrb_pred,
        .rrb_fp, .stage_pred, .pr_log_idx, .pr_phys_idx, .fr_log_idx, .fr_phys_idx
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "loop_cnt", loop_cnt, m_lc);
        chk(req, "epi_cnt", 64'(epi_cnt), 64'(m_ec));
        chk(req, "rrb_pred", 64'(rrb_pred), 64'(m_rp));
        chk(req, "rrb_fp", 64'(rrb_fp), 64'(m_rf));
        chk(req, "stage_pred", 64'(stage_pred), 64'(m_st));
    endtask

    task automatic model_rot();
        m_rp = (m_rp == 0) ? 47 : m_rp - 1;
        m_rf = (m_rf == 0) ? 95 : m_rf - 1;
    endtask

    // one branch request; checks taken in-cycle and state after the edge
    task automatic do_branch(input logic kind, input string req);
        logic exp_t;
        @(negedge clk);
        br_valid = 1'b1;
        br_kind = kind;
        #1;
        if (m_lc != 0) begin
            exp_t = ~kind; m_lc = m_lc - 1; m_st = 1'b1; model_rot();
        end else if (m_ec > 1) begin
            exp_t = ~kind; m_ec = m_ec - 1; m_st = 1'b0; model_rot();
        end else if (m_ec == 1) begin
            exp_t = kind; m_ec = 0; m_st = 1'b0; model_rot();
        end else begin
            exp_t = kind;
        end
        chk(req, "br_taken", 64'(br_taken), 64'(exp_t));
        @(negedge clk);
        br_valid = 1'b0;
        chk_state(req);
    endtask

    task automatic write_counts(input logic [63:0] lc, input logic [5:0] ec);
        @(negedge clk);
        lc_wr_en = 1'b1; lc_wr_data = lc;
        ec_wr_en = 1'b1; ec_wr_data = ec;
        @(negedge clk);
        lc_wr_en = 1'b0; ec_wr_en = 1'b0;
        m_lc = lc; m_ec = ec;
        chk_state("R2");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lc = 0; m_ec = 0; m_rp = 0; m_rf = 0; m_st = 1'b0;
        chk_state("R1");
    endtask

    task automatic t_full_loop();
        write_counts(64'd3, 6'd2);
        do_branch(1'b0, "R9");           // kernel, bases wrap from zero
        do_branch(1'b0, "R3");
        do_branch(1'b0, "R3");
        do_branch(1'b0, "R4");           // drain with count 2
        do_branch(1'b0, "R5");           // last drain, falls through
        do_branch(1'b0, "R6");           // done, nothing changes
        do_branch(1'b0, "R7");
    endtask

    task automatic t_leave_kind();
        write_counts(64'd1, 6'd3);
        do_branch(1'b1, "R8");
        do_branch(1'b1, "R8");
        do_branch(1'b1, "R8");
        do_branch(1'b1, "R8");
        do_branch(1'b1, "R8");
    endtask

    task automatic t_write_priority();
        write_counts(64'd5, 6'd1);
        @(negedge clk);
        br_valid = 1'b1; br_kind = 1'b0;
        lc_wr_en = 1'b1; lc_wr_data = 64'd9;
        @(negedge clk);
        br_valid = 1'b0; lc_wr_en = 1'b0;
        m_lc = 64'd9; m_st = 1'b1; model_rot();
        chk_state("R2");
    endtask

    task automatic t_wide_count();
        write_counts(64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
        do_branch(1'b0, "R3");
        do_branch(1'b1, "R3");
    endtask

    task automatic t_hold();
        repeat (4) @(negedge clk);
        chk_state("R12");
    endtask

    task automatic t_map();
        int exp;
        for (int n = 0; n < 64; n++) begin
            pr_log_idx = 6'(n);
            #1;
            exp = (n < 16) ? n : 16 + ((n - 16 + m_rp) % 48);
            chk("R10", "pr_phys_idx", 64'(pr_phys_idx), 64'(exp));
        end
        for (int n = 0; n < 128; n++) begin
            fr_log_idx = 7'(n);
            #1;
            exp = (n < 32) ? n : 32 + ((n - 32 + m_rf) % 96);
            chk("R11", "fr_phys_idx", 64'(fr_phys_idx), 64'(exp));
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_map();
        t_full_loop();
        t_map();
        t_leave_kind();
        t_write_priority();
        t_wide_count();
        t_hold();
        t_map();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule